// File: doc/BRIEF.md
# Event-Selected Cycle Counter Bank

This block is a set of six 32-bit performance counters for a processor core. Four of them are programmable: each reads an 8-bit event code from its own byte of a 64-bit selection register, and a per-counter decoder decides from that code whether the counter advances on each clock cycle. A fifth counter only holds whatever software writes into it. A sixth counter counts every cycle, whatever the selection register holds.

Two codes select cycle counting. 0x1E counts cycles in any of the four programmable counters. 0xF0 counts cycles only when it sits in the first counter's byte. Every other code leaves its counter untouched by the cycle logic. A global freeze input halts all six counters while it is high.

Software reaches the selection register and every counter through a flat register port. Writes are synchronous, with one write port. Reads are combinational from a separate read address.

Top module: `cyc_evt_ctr_bank`

## Requirements
- R1: The code for programmable counter k (k = 1..4) is taken from selection bits [31-8(k-1) : 24-8(k-1)]: counter 1 from [31:24], counter 2 from [23:16], counter 3 from [15:8] and counter 4 from [7:0]. Bits [63:32] select nothing.
- R2: Code 0xF0 advances counter 1 by one per unfrozen cycle. In the fields of counters 2 to 4 the same code does not advance the counter.
- R3: Code 0x1E advances by one per unfrozen cycle whichever of counters 1 to 4 it is programmed into.
- R4: Any other code leaves its counter unchanged. This includes the reserved range 0x01 to 0xBF, apart from 0x1E.
- R5: Counter 6 advances by one on every unfrozen cycle, regardless of the selection register.
- R6: Counter 5 never advances. It changes only on a software write.
- R7: Every counter is 32 bits wide and wraps from 0xFFFFFFFF to 0 without any flag.
- R8: While freeze_i is high, no counter advances, counter 6 included.
- R9: A write to a counter in the same cycle as its increment loads the written value, and the increment is lost.
- R10: A write to the selection register affects counting from the following cycle onward, not in the write cycle itself.
- R11: Synchronous active-high reset clears the selection register and all six counters.
- R12: The register map is as follows. Address 0 is the 64-bit selection register. Addresses 1 to 6 are counters 1 to 6, written from data bits [31:0] and read back with bits [63:32] as zero. Address 7 reads zero, and writes to it are ignored. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Global freeze; high halts all counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address (0 selection, 1..6 counters) |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 64 | Combinational read data |

## Verification
A decoder that ignored the counter index would let 0xF0 advance counters 2 to 4. A bench that only checked counter 1 would miss that, so the bench places 0xF0 in every field and mixes it with 0x1E in neighbouring fields. A misplaced field slice would make the wrong counter count, or let the upper word of the selection register select events, so the bench loads garbage codes into the upper word and into single fields. The bench also loads reserved codes next to 0x1E, to catch a decoder that matches too loosely. The remaining checks cover the counter boundaries: the wrap at all-ones, a write that collides with an increment and must win, and a selection write that must not count in its own cycle. They also check that freeze stops the always-counting counter, and that counter 5 stays put while the others run.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;

    localparam int CTR_W  = 32;
    localparam int SEL_W  = 64;
    localparam int CODE_W = 8;
    localparam int N_PROG = 4;
    localparam int N_CTR  = 6;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 64;

    // first programmable field ends just below the upper half of the selector
    localparam int FIELD0_MSB = SEL_W / 2 - 1;

    localparam logic [CODE_W-1:0] EVT_CYC_FIRST = 8'hF0;
    localparam logic [CODE_W-1:0] EVT_CYC_ANY   = 8'h1E;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEL  = 3'd0,
        RA_C1   = 3'd1,
        RA_C2   = 3'd2,
        RA_C3   = 3'd3,
        RA_C4   = 3'd4,
        RA_C5   = 3'd5,
        RA_C6   = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             wr;
        logic             inc;
        logic [CTR_W-1:0] wdata;
    } ctr_ctl_t;

    // event code of programmable counter idx (0-based)
    function automatic logic [CODE_W-1:0] code_of(input logic [SEL_W-1:0] sel,
                                                  input int idx);
        return sel[(FIELD0_MSB - idx * CODE_W) -: CODE_W];
    endfunction

endpackage

// File: rtl/cyc_evt_decode.sv
module cyc_evt_decode
    import cyc_ctr_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              adv_o
);

    generate
        if (IDX == 0) begin : g_first
            // first counter accepts both cycle codes
            assign adv_o = (code_i == EVT_CYC_ANY) || (code_i == EVT_CYC_FIRST);
        end else begin : g_other
            assign adv_o = (code_i == EVT_CYC_ANY);
        end
    endgenerate

endmodule

// File: rtl/cyc_ctr_reg.sv
module cyc_ctr_reg
    import cyc_ctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctr_ctl_t         ctl_i,
    output logic [CTR_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (ctl_i.wr) begin
            cnt_o <= ctl_i.wdata;
        end else if (ctl_i.inc) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R9
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_i.wr |=> cnt_o == $past(ctl_i.wdata));

    // R7
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.wr && ctl_i.inc) |=> cnt_o == CTR_W'($past(cnt_o) + 1'b1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.wr && !ctl_i.inc) |=> $stable(cnt_o));

endmodule

// File: rtl/cyc_evt_ctr_bank.sv
module cyc_evt_ctr_bank
    import cyc_ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [SEL_W-1:0] sel_q;
    logic [N_CTR-1:0] adv;
    logic [CTR_W-1:0] ctr_q [N_CTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en_i && wr_addr_i == RA_SEL) begin
            sel_q <= wr_data_i[SEL_W-1:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_PROG; gi++) begin : g_dec
            cyc_evt_decode #(.IDX(gi)) u_dec (
                .code_i (code_of(sel_q, gi)),
                .adv_o  (adv[gi])
            );
        end
        for (gi = N_PROG; gi < N_CTR; gi++) begin : g_fixed
            // last counter counts every cycle; the one before it never does
            assign adv[gi] = (gi == N_CTR - 1);
        end

        for (gi = 0; gi < N_CTR; gi++) begin : g_ctr
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi + 1);
            ctr_ctl_t ctl;
            always_comb begin
                ctl.wr    = wr_en_i && (wr_addr_i == MY_ADDR);
                ctl.inc   = !freeze_i && adv[gi];
                ctl.wdata = wr_data_i[CTR_W-1:0];
            end
            cyc_ctr_reg u_ctr (
                .clk   (clk),
                .rst   (rst),
                .ctl_i (ctl),
                .cnt_o (ctr_q[gi])
            );
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            RA_SEL:  rd_data_o = DATA_W'(sel_q);
            RA_C1:   rd_data_o = DATA_W'(ctr_q[0]);
            RA_C2:   rd_data_o = DATA_W'(ctr_q[1]);
            RA_C3:   rd_data_o = DATA_W'(ctr_q[2]);
            RA_C4:   rd_data_o = DATA_W'(ctr_q[3]);
            RA_C5:   rd_data_o = DATA_W'(ctr_q[4]);
            RA_C6:   rd_data_o = DATA_W'(ctr_q[5]);
            default: rd_data_o = '0;
        endcase
    end

    logic wr_c2, wr_c5, wr_c6;
    assign wr_c2 = wr_en_i && wr_addr_i == RA_C2;
    assign wr_c5 = wr_en_i && wr_addr_i == RA_C5;
    assign wr_c6 = wr_en_i && wr_addr_i == RA_C6;

    // R8
    freeze_c6_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && !wr_c6) |=> $stable(ctr_q[N_CTR-1]));

    // R5
    c6_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!freeze_i && !wr_c6) |=> ctr_q[N_CTR-1] == CTR_W'($past(ctr_q[N_CTR-1]) + 1'b1));

    // R6
    c5_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_c5 |=> $stable(ctr_q[4]));

    // R2
    f0_c2_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_c2 && sel_q[23:16] == EVT_CYC_FIRST) |=> $stable(ctr_q[1]));

    // R10
    sel_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == RA_SEL) |=> sel_q == $past(wr_data_i));

endmodule

// File: tb/cyc_evt_ctr_bank_tb.sv
`timescale 1ns/1ps
module cyc_evt_ctr_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = '0;
    logic [63:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cyc_evt_ctr_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .freeze_i  (freeze_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    typedef struct packed {
        logic [63:0] sel;
        logic [7:0]  n;
        logic [3:0]  mask;   // bit k-1 set: counter k expected to count
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{64'h0000_0000_0000_0000, 8'd5, 4'b0000},
        '{64'h0000_0000_F000_0000, 8'd7, 4'b0001},
        '{64'h0000_0000_F0F0_F0F0, 8'd4, 4'b0001},
        '{64'h0000_0000_1E1E_1E1E, 8'd6, 4'b1111},
        '{64'h0000_0000_0000_1E00, 8'd3, 4'b0100},
        '{64'h1E1E_1E1E_F000_0000, 8'd5, 4'b0001},
        '{64'h0000_0000_01BF_1F0F, 8'd5, 4'b0000},
        '{64'h0000_0000_001E_00F0, 8'd9, 4'b0010},
        '{64'h0000_0000_1EF0_0000, 8'd2, 4'b0001}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic run(input int n);
        freeze_i = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        freeze_i = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        rd_addr_i = a;
        #0.5;
        d = rd_data_o;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: everything zero while in reset
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R11 reset addr %0d", a), v, 64'h0);
        end
        rst = 1'b0;

        // table of selection patterns: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            for (int c = 1; c <= 6; c++) wr(3'(c), 64'h0);
            wr(3'd0, VEC[i].sel);
            run(int'(VEC[i].n));
            for (int c = 1; c <= 4; c++) begin
                rd(3'(c), v);
                check($sformatf("R1/R2/R3/R4 vec %0d ctr %0d", i, c), v,
                      VEC[i].mask[c-1] ? 64'(VEC[i].n) : 64'h0);
            end
            rd(3'd5, v);
            check($sformatf("R6 vec %0d ctr 5", i), v, 64'h0);
            rd(3'd6, v);
            check($sformatf("R5 vec %0d ctr 6", i), v, 64'(VEC[i].n));
        end

        // R7: wrap at all-ones
        wr(3'd1, 64'hFFFF_FFFF);
        wr(3'd6, 64'hFFFF_FFFE);
        wr(3'd0, 64'h1E00_0000);
        run(2);
        rd(3'd1, v); check("R7 ctr1 wrap", v, 64'h1);
        rd(3'd6, v); check("R7 ctr6 wrap", v, 64'h0);

        // R9: write collides with increment
        wr(3'd1, 64'h0);
        freeze_i = 1'b0;
        wr(3'd1, 64'h100);
        freeze_i = 1'b1;
        rd(3'd1, v); check("R9 write beats increment", v, 64'h100);

        // R6: counter 5 holds a written value while others run
        wr(3'd5, 64'h55);
        run(10);
        rd(3'd5, v); check("R6 ctr5 holds", v, 64'h55);

        // R10: selection write counts from the next cycle
        wr(3'd0, 64'h0);
        wr(3'd1, 64'h0);
        freeze_i = 1'b0;
        wr(3'd0, 64'hF000_0000);
        @(posedge clk);
        @(negedge clk);
        freeze_i = 1'b1;
        rd(3'd1, v); check("R10 sel write delayed", v, 64'h1);

        // R8: freeze stops all
        wr(3'd0, 64'h1E1E_1E1E);
        for (int c = 1; c <= 6; c++) wr(3'(c), 64'(c * 16));
        repeat (10) @(negedge clk);
        for (int c = 1; c <= 6; c++) begin
            rd(3'(c), v);
            check($sformatf("R8 frozen ctr %0d", c), v, 64'(c * 16));
        end

        // R12: register map
        wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3'd2, v); check("R12 upper bits zero", v, 64'h0000_0000_FFFF_FFFF);
        wr(3'd7, 64'hDEAD_BEEF_1234_5678);
        rd(3'd7, v); check("R12 addr 7 reads zero", v, 64'h0);
        rd(3'd0, v); check("R12 addr 7 write ignored", v, 64'h1E1E_1E1E);
        for (int c = 3; c <= 6; c++) begin
            rd(3'(c), v);
            check($sformatf("R12 addr 7 write left ctr %0d", c), v, 64'(c * 16));
        end
        wr(3'd0, 64'hA5A5_5A5A_0102_0304);
        rd(3'd0, v); check("R12 sel full readback", v, 64'hA5A5_5A5A_0102_0304);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule